// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit produces the 16-bit address that an 8-bit accumulator-based processor puts on its bus for one operand access. The decoder gives it an addressing mode together with a snapshot of the program counter, the HL pair, both index registers, the accumulator and up to two operand bytes. One clock later the unit presents the registered address, a memory or I/O request strobe and a valid flag.

It supports five modes. Register indirect uses HL. Extended takes the address from two instruction bytes. Relative forms a branch target from the opcode address. Indexed adds a signed displacement to IX or IY. Port I/O combines the port byte with the accumulator. Any other mode code raises an error flag and drives neither request strobe.

Top module: `addr_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `ea_addr` is 0 and `mem_req`, `io_req`, `ea_valid` and `ea_err` are all 0.
- R2: A request (`req_valid`=1) with a supported mode (codes 0 to 4) sets `ea_valid` to 1 in the cycle after it is sampled. A cycle with `req_valid`=0 produces `ea_valid`=0, `ea_err`=0, no strobe and `ea_addr`=0 one cycle later.
- R3: Mode 0 (register indirect) gives `ea_addr` = `hl`.
- R4: Mode 1 (extended) gives `ea_addr` = {`op_hi`, `op_lo`}, with `op_lo` as the low byte.
- R5: Mode 2 (relative) gives `ea_addr` = `pc` + 2 + the sign-extended `op_lo`, where `pc` is the address of the branch opcode. The reach is -126 to +129.
- R6: Mode 3 (indexed) gives `ea_addr` = base + the sign-extended `op_lo` (-128..+127). The base is `ix` when `idx_sel`=0 and `iy` when `idx_sel`=1.
- R7: Mode 4 (port I/O) gives `ea_addr` = {`acc`, `op_lo`}, with `io_req`=1 and `mem_req`=0.
- R8: Modes 0 to 3 give `mem_req`=1 and `io_req`=0. A valid result never has both strobes high.
- R9: Mode codes 5, 6 and 7 give `ea_err`=1, `ea_valid`=0, no strobe and `ea_addr`=0 one cycle later.
- R10: All address sums wrap modulo 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request qualifier for the mode and operand inputs |
| mode | input | 3 | Addressing mode code (0 to 4 supported) |
| idx_sel | input | 1 | Index base select: 0 selects IX, 1 selects IY |
| pc | input | 16 | Address of the current opcode |
| hl | input | 16 | HL register pair |
| ix | input | 16 | IX index register |
| iy | input | 16 | IY index register |
| acc | input | 8 | Accumulator |
| op_lo | input | 8 | First operand byte (low byte, offset, displacement or port) |
| op_hi | input | 8 | Second operand byte (high byte) |
| ea_addr | output | 16 | Registered effective address |
| mem_req | output | 1 | Memory request strobe |
| io_req | output | 1 | I/O request strobe |
| ea_valid | output | 1 | Result valid |
| ea_err | output | 1 | Unsupported mode flag |

## Verification
The bench uses the default parameters: 8-bit data, 16-bit addresses and a branch bias of 2. With 16-bit addresses, the bench can wrap the sum in both directions. It does this with a relative branch near 0xFFFF and an index base near 0x0000 with a negative displacement. With 8-bit operands, the offset extremes 0x7F and 0x80 probe the exact reach limits. All three unsupported codes are sent between valid requests to confirm that nothing leaks from one request into the next.

// File: rtl/eag_pkg.sv
package eag_pkg;
    typedef enum logic [2:0] {
        AM_IND = 3'd0,
        AM_EXT = 3'd1,
        AM_REL = 3'd2,
        AM_IDX = 3'd3,
        AM_IO  = 3'd4
    } amode_e;

    localparam int unsigned AM_LAST = 4;
endpackage

// File: rtl/eag_sext_add.sv
module eag_sext_add #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic [AW-1:0] base,
    input  logic [DW-1:0] disp,
    output logic [AW-1:0] sum
);
    localparam int unsigned EXT_W = AW - DW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DW-1]}}, disp};
        sum      = base + disp_ext;
    end
endmodule

// File: rtl/addr_gen.sv
module addr_gen
    import eag_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 8,
    parameter int unsigned REL_BIAS = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    mode,
    input  logic          idx_sel,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] hl,
    input  logic [AW-1:0] ix,
    input  logic [AW-1:0] iy,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] op_lo,
    input  logic [DW-1:0] op_hi,
    output logic [AW-1:0] ea_addr,
    output logic          mem_req,
    output logic          io_req,
    output logic          ea_valid,
    output logic          ea_err
);
    localparam int unsigned HI_W = AW - DW;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic          mreq;
        logic          iorq;
        logic          valid;
        logic          err;
    } ea_st_t;

    ea_st_t st_d, st_q;

    logic [AW-1:0] rel_base, idx_base, rel_sum, idx_sum;

    always_comb begin
        rel_base = pc + AW'(REL_BIAS);
        idx_base = idx_sel ? iy : ix;
    end

    eag_sext_add #(.AW(AW), .DW(DW)) u_rel_add (
        .base(rel_base), .disp(op_lo), .sum(rel_sum)
    );

    eag_sext_add #(.AW(AW), .DW(DW)) u_idx_add (
        .base(idx_base), .disp(op_lo), .sum(idx_sum)
    );

    always_comb begin
        st_d = '0;
        if (req_valid) begin
            st_d.valid = 1'b1;
            st_d.mreq  = 1'b1;
            unique case (mode)
                AM_IND:  st_d.addr = hl;
                AM_EXT:  st_d.addr = {op_hi[HI_W-1:0], op_lo};
                AM_REL:  st_d.addr = rel_sum;
                AM_IDX:  st_d.addr = idx_sum;
                AM_IO: begin
                    st_d.addr = {acc[HI_W-1:0], op_lo};
                    st_d.mreq = 1'b0;
                    st_d.iorq = 1'b1;
                end
                default: begin
                    st_d.valid = 1'b0;
                    st_d.mreq  = 1'b0;
                    st_d.err   = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ea_addr  = st_q.addr;
    assign mem_req  = st_q.mreq;
    assign io_req   = st_q.iorq;
    assign ea_valid = st_q.valid;
    assign ea_err   = st_q.err;

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ea_valid |-> $onehot({mem_req, io_req}));

    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ea_err |-> (!mem_req && !io_req && !ea_valid));

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode <= 3'(AM_LAST)) |=> ea_valid);

    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!ea_valid && !ea_err && !mem_req && !io_req));

    p_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_EXT) |=> ea_addr == {$past(op_hi[HI_W-1:0]), $past(op_lo)});

    p_io_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && mode == AM_IO) |=> (io_req && !mem_req && ea_addr[DW-1:0] == $past(op_lo)));
endmodule

// File: tb/addr_gen_tb.sv
`timescale 1ns/1ps
module addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  mode = '0;
    logic        idx_sel = 1'b0;
    logic [15:0] pc = '0, hl = '0, ix = '0, iy = '0;
    logic [7:0]  acc = '0, op_lo = '0, op_hi = '0;
    logic [15:0] ea_addr;
    logic        mem_req, io_req, ea_valid, ea_err;

    always #2.5 clk = ~clk;

    addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .mode(mode),
        .idx_sel(idx_sel), .pc(pc), .hl(hl), .ix(ix), .iy(iy), .acc(acc),
        .op_lo(op_lo), .op_hi(op_hi), .ea_addr(ea_addr), .mem_req(mem_req),
        .io_req(io_req), .ea_valid(ea_valid), .ea_err(ea_err)
    );

    typedef struct {
        logic [15:0] addr;
        logic        mreq;
        logic        iorq;
        logic        valid;
        logic        err;
        int          req;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   mon_on = 1'b0;

    function automatic logic [15:0] sx(input logic [7:0] b);
        return {{8{b[7]}}, b};
    endfunction

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic drive(input bit v, input logic [2:0] m, input bit isel,
                         input logic [15:0] p, input logic [15:0] h,
                         input logic [15:0] x, input logic [15:0] y,
                         input logic [7:0] a, input logic [7:0] lo,
                         input logic [7:0] hi, input int req);
        exp_t e;
        @(negedge clk);
        req_valid = v; mode = m; idx_sel = isel; pc = p; hl = h;
        ix = x; iy = y; acc = a; op_lo = lo; op_hi = hi;
        e = '{addr: 16'h0, mreq: 1'b0, iorq: 1'b0, valid: 1'b0, err: 1'b0, req: req};
        if (v) begin
            e.valid = 1'b1;
            e.mreq  = 1'b1;
            case (m)
                3'd0: e.addr = h;
                3'd1: e.addr = {hi, lo};
                3'd2: e.addr = p + 16'd2 + sx(lo);
                3'd3: e.addr = (isel ? y : x) + sx(lo);
                3'd4: begin e.addr = {a, lo}; e.mreq = 1'b0; e.iorq = 1'b1; end
                default: begin e.valid = 1'b0; e.mreq = 1'b0; e.err = 1'b1; end
            endcase
        end
        exp_q.push_back(e);
    endtask

    always @(posedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            exp_t e;
            #1;
            e = exp_q.pop_front();
            check(e.req, "addr",  32'(ea_addr),  32'(e.addr));
            check(e.req, "mreq",  32'(mem_req),  32'(e.mreq));
            check(e.req, "iorq",  32'(io_req),   32'(e.iorq));
            check(e.req, "valid", 32'(ea_valid), 32'(e.valid));
            check(e.req, "err",   32'(ea_err),   32'(e.err));
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(1, "reset addr",  32'(ea_addr), 32'h0);      // R1
        check(1, "reset flags", 32'({mem_req, io_req, ea_valid, ea_err}), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(1, "post-reset flags", 32'({mem_req, io_req, ea_valid, ea_err}), 32'h0);
        mon_on = 1'b1;
        // R3, R8: register indirect
        drive(1, 3'd0, 0, 16'h1000, 16'hBEEF, 0, 0, 8'h00, 8'h00, 8'h00, 3);
        // R4: extended, first byte is the low half
        drive(1, 3'd1, 0, 16'h1000, 16'h0, 0, 0, 8'h00, 8'h34, 8'h12, 4);
        // R2: idle cycle
        drive(0, 3'd1, 0, 0, 0, 0, 0, 8'h00, 8'h00, 8'h00, 2);
        // R5: relative at reach limits
        drive(1, 3'd2, 0, 16'h0200, 0, 0, 0, 0, 8'h7F, 0, 5);
        drive(1, 3'd2, 0, 16'h0200, 0, 0, 0, 0, 8'h80, 0, 5);
        drive(1, 3'd2, 0, 16'h0200, 0, 0, 0, 0, 8'hFE, 0, 5);
        // R10: wrap forward and backward
        drive(1, 3'd2, 0, 16'hFFFE, 0, 0, 0, 0, 8'h10, 0, 10);
        drive(1, 3'd3, 0, 0, 0, 16'h0005, 16'h9000, 0, 8'hF0, 0, 10);
        // R6: IX and IY selection
        drive(1, 3'd3, 0, 0, 0, 16'h4000, 16'h8000, 0, 8'h10, 0, 6);
        drive(1, 3'd3, 1, 0, 0, 16'h4000, 16'h8000, 0, 8'h80, 0, 6);
        // R7: port I/O
        drive(1, 3'd4, 0, 0, 16'h5555, 0, 0, 8'hA5, 8'h10, 8'h77, 7);
        // R9: unsupported codes between valid requests
        drive(1, 3'd5, 0, 16'h1234, 16'h5678, 0, 0, 8'h11, 8'h22, 8'h33, 9);
        drive(1, 3'd0, 0, 0, 16'h0042, 0, 0, 0, 0, 0, 8);
        drive(1, 3'd6, 1, 16'h1234, 16'h5678, 0, 0, 8'h11, 8'h22, 8'h33, 9);
        drive(1, 3'd7, 0, 16'h1234, 16'h5678, 0, 0, 8'h11, 8'h22, 8'h33, 9);
        drive(1, 3'd4, 0, 0, 0, 0, 0, 8'hFF, 8'hFF, 0, 7);
        drive(0, 3'd0, 0, 0, 0, 0, 0, 0, 0, 0, 2);
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule